// File: doc/BRIEF.md
# ADC Sample Accumulator and Averager

This stage sits between a converter and its result register. In the 16-bit result mode it adds up a power-of-two number of consecutive conversion results. It then shifts the total right by a programmable amount, limits the value to 16 bits and writes it to the result output. The ready pulse fires once, when the last sample of a run has been added. It does not fire for each conversion.

In the 12-, 10- and 8-bit modes there is no averaging. Each conversion goes straight to the result, narrowed to the chosen width, and raises a ready pulse of its own.

In every mode the result stays the same until the next update. The consumer can therefore read the previous value at any time while the next conversion or run is in progress.

Top module: `acc_avg_stage`

## Requirements
- R1: While reset is active and directly after it, `result` is 0 and `result_ready` is low.
- R2: The resolution select `res_mode` is encoded as 0 = 12-bit, 1 = 16-bit, 2 = 10-bit and 3 = 8-bit. In modes 0, 2 and 3, a sample with `conv_valid` high sets `result` in the next cycle, with a one-cycle `result_ready`. The value is the sample itself in mode 0, the sample shifted right by 2 in mode 2, and the sample shifted right by 4 in mode 3.
- R3: In mode 1, a run is 2^`cnt_code` samples for codes 0 to 10. Codes 11 to 15 behave as code 10, which gives 1024 samples.
- R4: At the end of a run, `result` becomes the run's sum shifted right by `shift_code` (0 to 7). `result_ready` is high for exactly one cycle, the cycle after the run's last sample. It stays low after every earlier sample of the run.
- R5: A shifted sum above 65535 is written as 65535.
- R6: `result` changes only in a cycle where `result_ready` is high. Between updates it holds its last value.
- R7: If a sample arrives while `cnt_code` or `shift_code` differs from its value at the previous sample of the run, the samples gathered so far are dropped. The new sample counts as the first sample of a new run that uses the new settings. This applies even when the sample would have completed the old run.
- R8: Once a run completes, the sum and the count start again from zero. Consecutive runs are therefore independent.
- R9: The sum holds 1024 full-scale 12-bit samples without overflow. With code 10 and shift 7, 1024 samples of 4095 give 32760.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_valid | input | 1 | A conversion result is present this cycle |
| conv_data | input | 12 | Conversion result |
| cnt_code | input | 4 | Samples per run, as a power of two |
| shift_code | input | 3 | Right shift applied to the run sum |
| res_mode | input | 2 | Resolution select (0 = 12-bit, 1 = 16-bit, 2 = 10-bit, 3 = 8-bit) |
| result | output | 16 | Result value |
| result_ready | output | 1 | One-cycle pulse when `result` has been updated |

## Verification
Two events can fall on the same sample: the completion of a run and the restart caused by a change of settings. The bench creates this overlap by sending three of four samples under one count code. It then changes the code on the sample that would have completed the run. The check is that no result from the old run appears. The sample instead starts, and with code 0 immediately completes, a run under the new code, so the result equals that single sample. A second overlap is between a shift change and a run that is still in progress. It is judged by the value of the shortened run that completes next.

// File: rtl/acc_avg_pkg.sv
package acc_avg_pkg;
    typedef enum logic [1:0] {
        RES_12 = 2'd0,
        RES_16 = 2'd1,
        RES_10 = 2'd2,
        RES_8  = 2'd3
    } res_mode_e;
endpackage

// File: rtl/acc_run_tracker.sv
module acc_run_tracker #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    parameter int SHIFT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               accum_en,
    input  logic [CODE_W-1:0]  cnt_code,
    input  logic [SHIFT_W-1:0] shift_code,
    output logic               first_o,
    output logic               last_o
);
    localparam int CNT_W = MAX_CODE + 1;
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CODE_W-1:0]  code;
        logic [SHIFT_W-1:0] shift;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  target_m1;
    logic [CNT_W-1:0]  idx;
    logic              cfg_chg;
    logic              take;

    always_comb begin
        eff_code  = (cnt_code > MAX_C) ? MAX_C : cnt_code;
        target_m1 = (CNT_W'(1) << eff_code) - CNT_W'(1);
        cfg_chg   = (eff_code != trk_q.code) || (shift_code != trk_q.shift);
        take      = smp_valid && accum_en;
        first_o   = take && ((trk_q.cnt == '0) || cfg_chg);
        idx       = first_o ? '0 : trk_q.cnt;
        last_o    = take && (idx == target_m1);

        trk_d = trk_q;
        if (smp_valid) begin
            if (accum_en) begin
                trk_d.cnt   = last_o ? '0 : idx + CNT_W'(1);
                trk_d.code  = eff_code;
                trk_d.shift = shift_code;
            end else begin
                trk_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/acc_scale_sat.sv
module acc_scale_sat #(
    parameter int IN_W    = 22,
    parameter int SHIFT_W = 3,
    parameter int OUT_W   = 16
) (
    input  logic [IN_W-1:0]    sum_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [OUT_W-1:0]   val_o
);
    logic [IN_W-1:0] shifted;
    assign shifted = sum_i >> shift_i;

    generate
        if (IN_W > OUT_W) begin : g_sat
            always_comb begin
                if (|shifted[IN_W-1:OUT_W]) val_o = '1;
                else                        val_o = shifted[OUT_W-1:0];
            end
        end else begin : g_ext
            assign val_o = OUT_W'(shifted);
        end
    endgenerate
endmodule

// File: rtl/acc_res_narrow.sv
module acc_res_narrow
    import acc_avg_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int OUT_W    = 16
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  res_mode_e           mode_i,
    output logic [OUT_W-1:0]    val_o
);
    localparam int DROP10 = (SAMPLE_W > 10) ? SAMPLE_W - 10 : 0;
    localparam int DROP8  = (SAMPLE_W > 8)  ? SAMPLE_W - 8  : 0;

    always_comb begin
        unique case (mode_i)
            RES_10:  val_o = OUT_W'(sample_i >> DROP10);
            RES_8:   val_o = OUT_W'(sample_i >> DROP8);
            default: val_o = OUT_W'(sample_i);
        endcase
    end
endmodule

// File: rtl/acc_avg_stage.sv
module acc_avg_stage
    import acc_avg_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 10,
    parameter int SHIFT_W  = 3,
    parameter int OUT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_valid,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic [CODE_W-1:0]   cnt_code,
    input  logic [SHIFT_W-1:0]  shift_code,
    input  logic [1:0]          res_mode,
    output logic [OUT_W-1:0]    result,
    output logic                result_ready
);
    localparam int ACC_W = SAMPLE_W + MAX_CODE;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OUT_W-1:0] res;
        logic             rdy;
    } st_t;

    st_t st_d, st_q;
    res_mode_e        mode;
    logic             accum_en;
    logic             first, last;
    logic [ACC_W-1:0] acc_sum;
    logic [OUT_W-1:0] scaled, narrow;

    assign mode     = res_mode_e'(res_mode);
    assign accum_en = (mode == RES_16);

    acc_run_tracker #(
        .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .SHIFT_W(SHIFT_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .smp_valid(conv_valid), .accum_en(accum_en),
        .cnt_code(cnt_code), .shift_code(shift_code),
        .first_o(first), .last_o(last)
    );

    assign acc_sum = (first ? '0 : st_q.acc) + ACC_W'(conv_data);

    acc_scale_sat #(.IN_W(ACC_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) u_sat (
        .sum_i(acc_sum), .shift_i(shift_code), .val_o(scaled)
    );

    acc_res_narrow #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_nar (
        .sample_i(conv_data), .mode_i(mode), .val_o(narrow)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b0;
        if (conv_valid) begin
            if (accum_en) begin
                if (last) begin
                    st_d.res = scaled;
                    st_d.rdy = 1'b1;
                    st_d.acc = '0;
                end else begin
                    st_d.acc = acc_sum;
                end
            end else begin
                st_d.res = narrow;
                st_d.rdy = 1'b1;
                st_d.acc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign result_ready = st_q.rdy;
endmodule

// File: rtl/acc_avg_checker.sv
module acc_avg_checker #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 4,
    parameter int SHIFT_W  = 3,
    parameter int OUT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                conv_valid,
    input logic [SAMPLE_W-1:0] conv_data,
    input logic [CODE_W-1:0]   cnt_code,
    input logic [SHIFT_W-1:0]  shift_code,
    input logic [1:0]          res_mode,
    input logic [OUT_W-1:0]    result,
    input logic                result_ready
);
    AST_READY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_ready |-> $past(conv_valid)); // R4
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !result_ready |-> $stable(result)); // R6
    AST_DIRECT_EACH: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && res_mode != 2'd1) |=> result_ready); // R2
    AST_EIGHT_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (result_ready && $past(res_mode) == 2'd3) |-> (result < 16'd256)); // R2
    AST_SINGLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && res_mode == 2'd1 && cnt_code == '0) |=> result_ready); // R3
endmodule

bind acc_avg_stage acc_avg_checker #(
    .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .cnt_code(cnt_code), .shift_code(shift_code), .res_mode(res_mode),
    .result(result), .result_ready(result_ready)
);

// File: tb/acc_avg_stage_bench.sv
module acc_avg_stage_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  cnt_code = '0;
    logic [2:0]  shift_code = '0;
    logic [1:0]  res_mode = '0;
    logic [15:0] result;
    logic        result_ready;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_avg_stage u_acc_avg_stage (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
        .cnt_code(cnt_code), .shift_code(shift_code), .res_mode(res_mode),
        .result(result), .result_ready(result_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample; returns at the negedge after the capturing edge
    task automatic send(input logic [11:0] d);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = d;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(result == 16'd0, "R1 result", result, 0);
        check(result_ready == 1'b0, "R1 ready", result_ready, 0);
    endtask

    task automatic t_direct();
        res_mode = 2'd0; send(12'hABC);
        check(result_ready, "R2 ready 12b", result_ready, 1);
        check(result == 16'h0ABC, "R2 12b", result, 'h0ABC);
        idle();
        check(!result_ready, "R6 ready drops", result_ready, 0);
        check(result == 16'h0ABC, "R6 hold", result, 'h0ABC);
        res_mode = 2'd2; send(12'hABC);
        check(result == 16'h02AF, "R2 10b", result, 'h02AF);
        res_mode = 2'd3; send(12'hABC);
        check(result == 16'h00AB, "R2 8b", result, 'h00AB);
    endtask

    task automatic t_run4();
        res_mode = 2'd1; cnt_code = 4'd2; shift_code = 3'd0;
        send(12'd10); check(!result_ready, "R4 no early ready", result_ready, 0);
        send(12'd20); check(!result_ready, "R4 no early ready", result_ready, 0);
        send(12'd30); check(result == 16'h00AB, "R6 held mid run", result, 'h00AB);
        send(12'd40);
        check(result_ready, "R4 ready at end", result_ready, 1);
        check(result == 16'd100, "R3 sum of 4", result, 100);
        idle(); check(!result_ready, "R4 single pulse", result_ready, 0);
    endtask

    task automatic t_shift();
        cnt_code = 4'd3; shift_code = 3'd3;
        for (int i = 1; i <= 8; i++) send(12'(i));
        check(result_ready && result == 16'd4, "R4 shifted", result, 4);
    endtask

    task automatic t_two_runs();
        cnt_code = 4'd1; shift_code = 3'd0;
        send(12'd5); send(12'd7);
        check(result == 16'd12, "R8 first run", result, 12);
        send(12'd1); send(12'd2);
        check(result == 16'd3, "R8 second run", result, 3);
    endtask

    task automatic t_single();
        cnt_code = 4'd0; shift_code = 3'd0;
        send(12'd123);
        check(result_ready && result == 16'd123, "R3 code 0", result, 123);
    endtask

    task automatic t_sat();
        cnt_code = 4'd5; shift_code = 3'd0;
        for (int i = 0; i < 32; i++) send(12'd4095);
        check(result == 16'hFFFF, "R5 saturate", result, 65535);
    endtask

    task automatic t_full();
        cnt_code = 4'd10; shift_code = 3'd7;
        for (int i = 0; i < 1024; i++) send(12'd4095);
        check(result_ready && result == 16'd32760, "R9 full run", result, 32760);
        cnt_code = 4'd15;
        for (int i = 0; i < 1023; i++) send(12'd4095);
        check(!result_ready, "R3 code 15 not early", result_ready, 0);
        send(12'd4095);
        check(result_ready && result == 16'd32760, "R3 code 15 as 10", result, 32760);
    endtask

    task automatic t_restart();
        cnt_code = 4'd2; shift_code = 3'd0;
        send(12'd100); send(12'd100);
        cnt_code = 4'd1;
        send(12'd3); check(!result_ready, "R7 restart not done", result_ready, 0);
        send(12'd4);
        check(result_ready && result == 16'd7, "R7 count change", result, 7);
        send(12'd50);
        shift_code = 3'd1;
        send(12'd6); send(12'd8);
        check(result == 16'd7, "R7 shift change", result, 7);
        cnt_code = 4'd2; shift_code = 3'd0;
        send(12'd1); send(12'd1); send(12'd1);
        cnt_code = 4'd0;
        send(12'd9);
        check(result_ready && result == 16'd9, "R7 change on last", result, 9);
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 3);
                t_reset();
                @(negedge clk); rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_direct();
                t_run4();
                t_shift();
                t_two_runs();
                t_single();
                t_sat();
                t_full();
                t_restart();
            end
            begin
                #(CLK_PERIOD * 100000);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule